// File: doc/BRIEF.md
# Phased SPI Master Transaction Engine

This block is a register-programmed SPI master. One transaction is made of up to three phases that always run in the same order: a command phase, an address phase and a data phase. Software enables each phase on its own and programs its length as a bit count minus one. The data phase moves bits in one direction only. It either transmits from a sixteen-word buffer of 32 bits or receives into that same buffer, starting at word 0.

Software fills the buffer and the configuration registers, then writes the start bit. The start bit reads back as busy until the transaction ends. A done flag is then set and stays set until software clears it. Serial timing comes from an external half-period enable, `sck_tick_i`; every SCK level lasts one tick. Clock idle level, sampling edge, bit order per direction, and extra chip-select setup and hold time are all configurable.

Register map, in word addresses on `reg_addr_i`:
- 0 is control. Bit 0 is go/busy and bit 1 is done.
- 1 is configuration.
- 2 is command.
- 3 is address.
- 4 holds the lengths.
- 16 to 31 are buffer words 0 to 15.

Top module: `spi_phase_master`

## Requirements
- R1: After reset `cs_no` is 1, `sck_o` is 0, and control, configuration, command, address, length and every buffer word read 0.
- R2: Writing 1 to control bit 0 while idle starts a transaction. Control bit 0 reads 1 from the next cycle until the transaction finishes, then reads 0. Writing go while busy has no effect.
- R3: Control bit 1 (done) becomes 1 in the same cycle that busy falls. It stays 1 until software writes 1 to control bit 1.
- R4: The phases run in the order command, address, data, and a disabled phase sends no SCK cycles. Configuration bit 8 enables the command phase, bit 9 the address phase, bit 10 MOSI data and bit 11 MISO data. The command register holds the value in bits 15:0 and the length minus one in bits 19:16. The command is sent MSB first over that many bits. The address register holds a 32-bit value whose length minus one sits in length-register bits 4:0, and it is sent MSB first.
- R5: The transmit data length is length-register bits 24:16 plus one, from 1 to 512 bits. Data bit n is taken from buffer word n/32 and byte (n/8)%4, so the low byte of each word goes first. Inside the byte it uses bit n%8 when configuration bit 2 is 1 (LSB first), else bit 7-(n%8).
- R6: With only MISO data enabled, received data bit n goes to the same word and byte as in R5. Configuration bit 3 picks the order inside the byte. All other buffer bits keep their value and MOSI stays 0. If both data enables are set, the phase transmits and the buffer is unchanged.
- R7: SCK idles at configuration bit 0 (polarity). Each bit takes two ticks, and MOSI changes only at the start of a bit. With configuration bit 1 (phase) at 0, the slave samples on the first edge of each bit; with it at 1, on the second edge.
- R8: Chip select falls when go is accepted. The first SCK edge comes 1 tick later (phase 1) or 2 ticks later (phase 0), plus 2 more when configuration bit 4 is set. Chip select rises 1 tick (phase 0) or 2 ticks (phase 1) after the last edge, plus 2 when configuration bit 5 is set.
- R9: While busy, writes to the configuration, command, address, length and buffer registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| sck_tick_i | input | 1 | Half-period enable for SCK |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong phase pointer or bit counter shows up on MOSI within one bit time as a misplaced or missing bit. It also changes the number of sample edges seen inside the chip-select window. A wrong bit-to-buffer mapping on receive only shows up when the buffer is read back after busy clears, so every word is compared then. A setup or hold counter that is off by one moves the first or last SCK edge by one tick against the chip-select edges, and the bench measures this on every transaction in all four modes.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;
  localparam int BUF_WORDS = 16;
  localparam int WORD_W    = 32;
  localparam int CMD_W     = 16;
  localparam int CMD_LW    = $clog2(CMD_W);
  localparam int ADR_W     = 32;
  localparam int ADR_LW    = $clog2(ADR_W);
  localparam int DAT_LW    = $clog2(BUF_WORDS * WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD} seq_st_e;
  typedef enum logic [1:0] {P_CMD = 2'd0, P_ADDR = 2'd1, P_DATA = 2'd2} phase_e;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              tx_lsb;
    logic              rx_lsb;
    logic              cs_setup;
    logic              cs_hold;
    logic              cmd_en;
    logic              addr_en;
    logic              mosi_en;
    logic              miso_en;
    logic [CMD_LW-1:0] cmd_len;
    logic [CMD_W-1:0]  cmd_val;
    logic [ADR_LW-1:0] addr_len;
    logic [ADR_W-1:0]  addr_val;
    logic [DAT_LW-1:0] data_len;
  } cfg_t;
endpackage

// File: rtl/spi_phase_regs.sv
module spi_phase_regs
  import spi_phase_pkg::*;
#(
  parameter int N_WORDS = BUF_WORDS,
  localparam int WIDX_W = $clog2(N_WORDS),
  localparam int AW     = WIDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [WORD_W-1:0] buf_rdata_i,
  output cfg_t              cfg_o,
  output logic              go_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              buf_we_o,
  output logic [WIDX_W-1:0] buf_idx_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);
  localparam logic [AW-1:0] A_CMD  = AW'(2);
  localparam logic [AW-1:0] A_ADR  = AW'(3);
  localparam logic [AW-1:0] A_LEN  = AW'(4);

  cfg_t cfg_q;
  logic done_q;
  logic in_buf, cfg_wr, done_clr;

  assign in_buf    = addr_i[AW-1];
  assign buf_idx_o = addr_i[WIDX_W-1:0];
  assign buf_we_o  = we_i && in_buf && !busy_i;
  assign cfg_wr    = we_i && !in_buf && !busy_i;
  assign go_o      = we_i && (addr_i == A_CTRL) && wdata_i[0] && !busy_i;
  assign done_clr  = we_i && (addr_i == A_CTRL) && wdata_i[1];
  assign cfg_o     = cfg_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (fin_i)         done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (cfg_wr) begin
        unique case (addr_i)
          A_CFG: begin
            cfg_q.cpol     <= wdata_i[0];
            cfg_q.cpha     <= wdata_i[1];
            cfg_q.tx_lsb   <= wdata_i[2];
            cfg_q.rx_lsb   <= wdata_i[3];
            cfg_q.cs_setup <= wdata_i[4];
            cfg_q.cs_hold  <= wdata_i[5];
            cfg_q.cmd_en   <= wdata_i[8];
            cfg_q.addr_en  <= wdata_i[9];
            cfg_q.mosi_en  <= wdata_i[10];
            cfg_q.miso_en  <= wdata_i[11];
          end
          A_CMD: begin
            cfg_q.cmd_val <= wdata_i[CMD_W-1:0];
            cfg_q.cmd_len <= wdata_i[16 +: CMD_LW];
          end
          A_ADR: cfg_q.addr_val <= wdata_i[ADR_W-1:0];
          A_LEN: begin
            cfg_q.addr_len <= wdata_i[ADR_LW-1:0];
            cfg_q.data_len <= wdata_i[16 +: DAT_LW];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_buf) rdata_o = buf_rdata_i;
    else begin
      unique case (addr_i)
        A_CTRL: rdata_o = {30'b0, done_q, busy_i};
        A_CFG:  rdata_o = {20'b0, cfg_q.miso_en, cfg_q.mosi_en, cfg_q.addr_en, cfg_q.cmd_en,
                           2'b0, cfg_q.cs_hold, cfg_q.cs_setup, cfg_q.rx_lsb, cfg_q.tx_lsb,
                           cfg_q.cpha, cfg_q.cpol};
        A_CMD:  rdata_o = {{(WORD_W-16-CMD_LW){1'b0}}, cfg_q.cmd_len, cfg_q.cmd_val};
        A_ADR:  rdata_o = cfg_q.addr_val;
        A_LEN:  rdata_o = {{(WORD_W-16-DAT_LW){1'b0}}, cfg_q.data_len,
                           {(16-ADR_LW){1'b0}}, cfg_q.addr_len};
        default: rdata_o = '0;
      endcase
    end
  end

  // R9: configuration frozen while a transaction runs
  a_r9_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cfg_q));
endmodule

// File: rtl/spi_phase_buf.sv
module spi_phase_buf
  import spi_phase_pkg::*;
#(
  parameter int N_WORDS = BUF_WORDS,
  localparam int WIDX_W = $clog2(N_WORDS),
  localparam int BPOS_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [WIDX_W-1:0] bus_idx_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic [WIDX_W-1:0] bit_idx_i,
  input  logic [BPOS_W-1:0] bit_pos_i,
  input  logic              bit_we_i,
  input  logic              bit_val_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] mem_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= '0;
      else if (bus_we_i && bus_idx_i == WIDX_W'(w)) mem_q[w] <= bus_wdata_i;
      else if (bit_we_i && bit_idx_i == WIDX_W'(w)) mem_q[w][bit_pos_i] <= bit_val_i;
    end
  end

  assign bus_rdata_o = mem_q[bus_idx_i];
  assign bit_o       = mem_q[bit_idx_i][bit_pos_i];

  // bus and shift writes never overlap
  a_r9_no_write_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bit_we_i));
endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
  import spi_phase_pkg::*;
#(
  parameter int N_WORDS = BUF_WORDS,
  localparam int WIDX_W = $clog2(N_WORDS),
  localparam int BPOS_W = $clog2(WORD_W),
  localparam int DCNT_W = DAT_LW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_t              cfg_i,
  input  logic              go_i,
  input  logic              tick_i,
  input  logic              miso_i,
  input  logic              tx_bit_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic [WIDX_W-1:0] bit_idx_o,
  output logic [BPOS_W-1:0] bit_pos_o,
  output logic              rx_we_o,
  output logic              rx_bit_o
);
  seq_st_e            st_q;
  phase_e             ph_q, nxt_ph;
  logic               half_q, nxt_ok, cur_last, data_en, data_tx, lsb;
  logic [DCNT_W-1:0]  cnt_q, setup_lim, hold_lim;
  logic [2:0]         en_vec;
  logic [1:0]         start;

  assign data_en   = cfg_i.mosi_en || cfg_i.miso_en;
  assign data_tx   = cfg_i.mosi_en;
  assign lsb       = data_tx ? cfg_i.tx_lsb : cfg_i.rx_lsb;
  assign en_vec    = {data_en, cfg_i.addr_en, cfg_i.cmd_en};
  assign setup_lim = cfg_i.cs_setup ? DCNT_W'(2) : '0;
  assign hold_lim  = cfg_i.cs_hold  ? DCNT_W'(2) : '0;
  assign start     = (st_q == S_SETUP) ? 2'd0 : 2'(ph_q) + 2'd1;

  // lowest enabled phase at or after start
  always_comb begin
    nxt_ok = 1'b0;
    nxt_ph = P_CMD;
    for (int p = 2; p >= 0; p--) begin
      if (p >= int'(start) && en_vec[p]) begin
        nxt_ok = 1'b1;
        nxt_ph = phase_e'(p);
      end
    end
  end

  always_comb begin
    unique case (ph_q)
      P_CMD:   cur_last = (cnt_q == DCNT_W'(cfg_i.cmd_len));
      P_ADDR:  cur_last = (cnt_q == DCNT_W'(cfg_i.addr_len));
      default: cur_last = (cnt_q == cfg_i.data_len);
    endcase
  end

  // data bit n: word n/32, byte (n/8)%4 from the low byte, bit order inside the byte
  assign bit_idx_o = cnt_q[BPOS_W +: WIDX_W];
  assign bit_pos_o = {cnt_q[BPOS_W-1:3], lsb ? cnt_q[2:0] : ~cnt_q[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ph_q   <= P_CMD;
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (go_i) begin
          st_q  <= S_SETUP;
          cnt_q <= '0;
        end
        S_SETUP: if (tick_i) begin
          if (cnt_q == setup_lim) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
            if (nxt_ok) begin
              st_q <= S_SHIFT;
              ph_q <= nxt_ph;
            end else st_q <= S_HOLD;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_SHIFT: if (tick_i) begin
          if (!half_q) half_q <= 1'b1;
          else begin
            half_q <= 1'b0;
            if (cur_last) begin
              cnt_q <= '0;
              if (nxt_ok) ph_q <= nxt_ph;
              else        st_q <= S_HOLD;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        S_HOLD: if (tick_i) begin
          if (cnt_q == hold_lim) st_q <= S_IDLE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign cs_no    = (st_q == S_IDLE);
  assign fin_o    = (st_q == S_HOLD) && tick_i && (cnt_q == hold_lim);
  assign sck_o    = (st_q == S_SHIFT) ? (cfg_i.cpol ^ half_q ^ cfg_i.cpha) : cfg_i.cpol;
  assign rx_we_o  = (st_q == S_SHIFT) && tick_i && !half_q && (ph_q == P_DATA) && !data_tx;
  assign rx_bit_o = miso_i;

  always_comb begin
    mosi_o = 1'b0;
    if (st_q == S_SHIFT) begin
      unique case (ph_q)
        P_CMD:   mosi_o = cfg_i.cmd_val[cfg_i.cmd_len - cnt_q[CMD_LW-1:0]];
        P_ADDR:  mosi_o = cfg_i.addr_val[cfg_i.addr_len - cnt_q[ADR_LW-1:0]];
        default: mosi_o = data_tx && tx_bit_i;
      endcase
    end
  end

  // R7: SCK moves only inside the chip-select window
  a_r7_sck_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sck_o) && $stable(cfg_i.cpol)) |-> !cs_no);
  // R8: chip select never falls together with an SCK edge
  a_r8_cs_before_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $stable(sck_o));
  // R7: MOSI holds through the second half of each bit
  a_r7_mosi_half_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SHIFT && half_q && $past(st_q == S_SHIFT && half_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
  import spi_phase_pkg::*;
#(
  parameter int N_WORDS = BUF_WORDS,
  localparam int WIDX_W = $clog2(N_WORDS),
  localparam int BPOS_W = $clog2(WORD_W),
  localparam int AW     = WIDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              sck_tick_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  cfg_t              cfg;
  logic              go, done, busy, fin, buf_we, rx_we, rx_bit, tx_bit;
  logic [WIDX_W-1:0] buf_idx, bit_idx;
  logic [BPOS_W-1:0] bit_pos;
  logic [WORD_W-1:0] buf_rdata;

  spi_phase_regs #(.N_WORDS(N_WORDS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .fin_i(fin), .buf_rdata_i(buf_rdata),
    .cfg_o(cfg), .go_o(go), .done_o(done), .rdata_o(reg_rdata_o),
    .buf_we_o(buf_we), .buf_idx_o(buf_idx)
  );

  spi_phase_buf #(.N_WORDS(N_WORDS)) u_buf (
    .clk_i, .rst_ni,
    .bus_we_i(buf_we), .bus_idx_i(buf_idx), .bus_wdata_i(reg_wdata_i),
    .bus_rdata_o(buf_rdata),
    .bit_idx_i(bit_idx), .bit_pos_i(bit_pos),
    .bit_we_i(rx_we), .bit_val_i(rx_bit), .bit_o(tx_bit)
  );

  spi_phase_seq #(.N_WORDS(N_WORDS)) u_seq (
    .clk_i, .rst_ni,
    .cfg_i(cfg), .go_i(go), .tick_i(sck_tick_i), .miso_i(miso_i), .tx_bit_i(tx_bit),
    .busy_o(busy), .fin_o(fin), .sck_o(sck_o), .cs_no(cs_no), .mosi_o(mosi_o),
    .bit_idx_o(bit_idx), .bit_pos_o(bit_pos), .rx_we_o(rx_we), .rx_bit_o(rx_bit)
  );

  // R3: done rises exactly when busy drops
  a_r3_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $fell(busy));
  // R3: done is sticky until an explicit clear
  a_r3_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !(reg_we_i && reg_addr_i == '0 && reg_wdata_i[1])) |=> done);
  // R2: busy only starts from an accepted go write
  a_r2_busy_from_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(go));
endmodule

// File: tb/tb_spi_phase_master.sv
module tb_spi_phase_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, tick = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, cs_n, mosi, miso;

  int errors = 0, checks = 0, cyc = 0;

  logic [31:0] pat [16];
  logic [31:0] expb [16];
  logic        rx_bits [640];
  logic        exp_tx [640];
  logic        cap [640];
  int exp_n, cap_n, samp_cnt, edges, st_ticks, ed_ticks, first_ticks, hold_ticks;
  logic cur_cpha = 1'b0, prev_cs = 1'b1, prev_sck = 1'b0;

  always #4 clk = ~clk;

  spi_phase_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sck_tick_i(tick), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi),
    .miso_i(miso)
  );

  assign miso = rx_bits[samp_cnt];

  always @(negedge clk) if (rst_n) tick = ~tick;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<180000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // slave-side monitor, sampled after outputs settle
  always @(posedge clk) begin
    #2;
    if (prev_cs && !cs_n) begin
      st_ticks = 0; ed_ticks = 0; edges = 0; cap_n = 0; samp_cnt = 0;
    end else if (!cs_n || !prev_cs) begin
      if (tick) begin st_ticks++; ed_ticks++; end
      if (!cs_n && sck !== prev_sck) begin
        edges++;
        if (edges == 1) first_ticks = st_ticks;
        ed_ticks = 0;
        if ((cur_cpha == 1'b0) ? (edges % 2 == 1) : (edges % 2 == 0)) begin
          cap[cap_n] = mosi; cap_n++; samp_cnt++;
        end
      end
      if (!prev_cs && cs_n) hold_ticks = ed_ticks;
    end
    prev_cs = cs_n; prev_sck = sck;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic int dpos(input int n, input logic lsb);
    int b = n / 8;
    return (b % 4) * 8 + (lsb ? n % 8 : 7 - n % 8);
  endfunction

  task automatic xfer(input int k);
    int mode = k % 4;
    logic ord = 1'((k / 4) % 2);
    logic rxm = 1'((k / 8) % 2);
    logic cpol = 1'(mode / 2), cpha = 1'(mode % 2);
    logic su = 1'((k / 2) % 2), ho = 1'(((k + 1) / 2) % 2);
    logic cen = (k % 3 != 2) || k == 16, aen = (k % 5 != 3) && k != 16;
    logic men = !rxm || k == 17, ien = rxm || k == 17;
    int lc = (k * 5) % 16, la = (k * 7) % 32, ld;
    logic [15:0] cval = 16'hC3A5 ^ 16'(k * 16'h1111);
    logic [31:0] aval = 32'h1234_5678 ^ (k * 32'h0F0F_0F0F);
    logic [31:0] cfgw, r;
    int off, polls, bad, firstbad, lim_s, lim_h;
    if (k == 16) begin men = 1'b0; ien = 1'b0; end
    ld = (k == 0) ? 0 : (k == 15 || k == 9) ? 511 : (k * 37) % 100;
    cur_cpha = cpha;
    cfgw = {20'b0, ien, men, aen, cen, 2'b0, ho, su, ~ord, ord, cpha, cpol};
    for (int i = 0; i < 640; i++) rx_bits[i] = ((i * 13 + k * 5) % 7) < 3;
    for (int w = 0; w < 16; w++) begin
      pat[w] = 32'h9E37_79B9 * (w + 1) + k;
      expb[w] = pat[w];
      wr(5'(16 + w), pat[w]);
    end
    wr(5'd1, cfgw);
    wr(5'd2, {12'b0, 4'(lc), cval});
    wr(5'd3, aval);
    wr(5'd4, {7'b0, 9'(ld), 11'b0, 5'(la)});
    // expected MOSI stream and receive image
    exp_n = 0;
    if (cen) for (int i = lc; i >= 0; i--) begin exp_tx[exp_n] = cval[i]; exp_n++; end
    if (aen) for (int i = la; i >= 0; i--) begin exp_tx[exp_n] = aval[i]; exp_n++; end
    off = exp_n;
    if (men || ien) for (int n = 0; n <= ld; n++) begin
      if (men) exp_tx[exp_n] = pat[n / 32][dpos(n, ord)];
      else begin
        exp_tx[exp_n] = 1'b0;
        expb[n / 32][dpos(n, ~ord)] = rx_bits[off + n];
      end
      exp_n++;
    end
    wr(5'd0, 32'h1);
    rd(5'd0, r);
    chk("R2 busy after go", r, 32'h1);
    if (k == 5) begin
      // R9: writes while busy must leave everything unchanged
      wr(5'd1, 32'hFFFF_FFFF); wr(5'd2, 32'hFFFF_FFFF); wr(5'd3, 32'h0);
      wr(5'd4, 32'hFFFF_FFFF); wr(5'd19, 32'hDEAD_BEEF); wr(5'd0, 32'h1);
    end
    polls = 0;
    do begin rd(5'd0, r); polls++; end while (r[0] && polls < 20000);
    chk("R2 busy clears, R3 done set", r, 32'h2);
    bad = 0; firstbad = -1;
    for (int i = 0; i < exp_n; i++)
      if (i >= cap_n || cap[i] !== exp_tx[i]) begin bad++; if (firstbad < 0) firstbad = i; end
    chk("R4 R5 R7 sample count", 32'(cap_n), 32'(exp_n));
    chk("R4 R5 R6 R7 mosi bits wrong (first index)", 32'(firstbad), 32'hFFFF_FFFF);
    lim_s = su ? 2 : 0; lim_h = ho ? 2 : 0;
    chk("R8 setup ticks", 32'(first_ticks), 32'(lim_s + (cpha ? 1 : 2)));
    chk("R8 hold ticks", 32'(hold_ticks), 32'(lim_h + (cpha ? 2 : 1)));
    for (int w = 0; w < 16; w++) begin
      rd(5'(16 + w), r);
      chk(ien && !men ? "R6 rx buffer word" : "R6 R9 buffer unchanged", r, expb[w]);
    end
    rd(5'd1, r);
    chk("R9 cfg kept", r, cfgw);
    rd(5'd3, r);
    chk("R9 addr kept", r, aval);
    rd(5'd0, r);
    chk("R3 done sticky", r, 32'h2);
    wr(5'd0, 32'h2);
    rd(5'd0, r);
    chk("R3 done cleared", r, 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    cap_n = 0; samp_cnt = 0; edges = 0; st_ticks = 0; ed_ticks = 0;
    first_ticks = 0; hold_ticks = 0; exp_n = 0;
    for (int i = 0; i < 640; i++) rx_bits[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cs idle", 32'(cs_n), 32'h1);
    chk("R1 sck idle", 32'(sck), 32'h0);
    for (int a = 0; a < 5; a++) begin
      rd(5'(a), r);
      chk("R1 register reset", r, 32'h0);
    end
    rd(5'd16, r); chk("R1 buffer first word", r, 32'h0);
    rd(5'd31, r); chk("R1 buffer last word", r, 32'h0);
    for (int k = 0; k < 18; k++) xfer(k);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule